// File: doc/BRIEF.md
# Reset-Key Discriminator and Status LED Driver

This block sits behind a debounced, active-low reset key and decides what each press means from how long it is held. A press that reaches the hold threshold issues a one-cycle full-system-reset pulse, which the rest of the recorder uses to erase the stored recording. The pulse fires at the moment the threshold is crossed, while the key is still down. A press released before the threshold issues a one-cycle play-pointer-reset pulse instead, so the next playback starts from the beginning. The threshold is either four seconds or two seconds, chosen by an input. All time is counted in system clock cycles, and `TICKS_PER_SEC` gives the number of cycles in one second (nominally 384000).

The block also drives the status LED. The LED pin is open-drain, so it is modelled as an enable plus a level that is fixed low. The LED is off in standby and steadily on while recording. During playback it follows a level-above-threshold flag from the audio path. While the system is being wiped it flashes at 2 Hz with a 50% duty cycle.

Top module: `keyled_ctrl`

## Requirements
- R1: When the key (`key_n` low) is held for the threshold number of cycles, `sys_rst` is high for one cycle after the clock edge that counts the last of those held cycles, whether or not the key is still held.
- R2: A press of 1 to threshold-1 held cycles gives one `play_rst` pulse on the cycle after release, and no `sys_rst`.
- R3: With `thr_short`=0 the threshold is 4*`TICKS_PER_SEC` cycles. With `thr_short`=1 it is 2*`TICKS_PER_SEC` cycles.
- R4: A press that has already produced `sys_rst` produces no further pulse of either kind, however long it is held and when it is released.
- R5: With `op_state`=2'b00 (standby), `led_oe` is 0 from the next cycle on, whatever `level_hi` does.
- R6: With `op_state`=2'b01 (recording), `led_oe` is 1 from the next cycle on.
- R7: With `op_state`=2'b10 (playback), `led_oe` equals the `level_hi` value of the previous cycle.
- R8: With `op_state`=2'b11 (wiping), `led_oe` alternates with on and off phases of `TICKS_PER_SEC`/4 cycles each, so the full period is 0.5 s. The on phase comes first, starting on the first cycle after entry.
- R9: After reset, `sys_rst`, `play_rst` and `led_oe` are 0, and `led_lvl` is always 0.
- R10: Each reset pulse lasts exactly one cycle, and the two pulses are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| key_n | input | 1 | Debounced reset key, low while pressed |
| thr_short | input | 1 | 1 selects the 2 s threshold, 0 selects the 4 s threshold |
| op_state | input | 2 | Operating state: 00 standby, 01 recording, 10 playback, 11 wiping |
| level_hi | input | 1 | Audio level above threshold |
| sys_rst | output | 1 | One-cycle full system reset request |
| play_rst | output | 1 | One-cycle play-pointer reset request |
| led_oe | output | 1 | LED pin drive enable (1 turns the LED on) |
| led_lvl | output | 1 | LED pin level when driven, fixed 0 |

## Verification
A hold counter that is off by one moves the `sys_rst` pulse one cycle away from the threshold edge. It also turns a press of exactly threshold-1 or threshold cycles into the wrong pulse kind. Both are visible on the first such press. A lost "already fired" flag shows up as a stray `play_rst` on the release after a long press. A wrong blink counter shifts the wiping phase boundaries within the first `TICKS_PER_SEC`/2 cycles. A wrong LED selection shows on `led_oe` one cycle after the state code changes.

// File: rtl/keyled_pkg.sv
package keyled_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_REC  = 2'b01,
    ST_PLAY = 2'b10,
    ST_WIPE = 2'b11
  } op_state_e;
endpackage

// File: rtl/press_timer.sv
module press_timer #(
  parameter int LONG_TICKS  = 1536000,
  parameter int SHORT_TICKS = 768000,
  localparam int CW = $clog2(LONG_TICKS + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic key_n,
  input  logic thr_short,
  output logic sys_rst_o,
  output logic play_rst_o
);
  logic [CW-1:0] cnt_q, cnt_d, lim_m1;
  logic          fired_q, fired_d;
  logic          sys_d, play_d, sys_q, play_q;

  // last held-cycle count before the threshold is reached
  assign lim_m1 = thr_short ? CW'(SHORT_TICKS - 1) : CW'(LONG_TICKS - 1);

  always_comb begin
    cnt_d   = cnt_q;
    fired_d = fired_q;
    sys_d   = 1'b0;
    play_d  = 1'b0;
    if (!key_n) begin
      if (!fired_q) begin
        if (cnt_q >= lim_m1) begin
          sys_d   = 1'b1;
          fired_d = 1'b1;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
    end else begin
      play_d  = (cnt_q != '0) && !fired_q;
      cnt_d   = '0;
      fired_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      fired_q <= 1'b0;
      sys_q   <= 1'b0;
      play_q  <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      fired_q <= fired_d;
      sys_q   <= sys_d;
      play_q  <= play_d;
    end
  end

  assign sys_rst_o  = sys_q;
  assign play_rst_o = play_q;
endmodule

// File: rtl/blink_gen.sv
module blink_gen #(
  parameter int HALF = 96000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic phase_o
);
  logic phase_q, phase_d;

  generate
    if (HALF > 1) begin : g_count
      localparam int HW = $clog2(HALF);
      logic [HW-1:0] cnt_q, cnt_d;
      always_comb begin
        cnt_d   = '0;
        phase_d = 1'b1;
        if (run) begin
          if (cnt_q == HW'(HALF - 1)) begin
            cnt_d   = '0;
            phase_d = !phase_q;
          end else begin
            cnt_d   = cnt_q + 1'b1;
            phase_d = phase_q;
          end
        end
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
      end
    end else begin : g_toggle
      always_comb phase_d = run ? !phase_q : 1'b1;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= 1'b1;
    else        phase_q <= phase_d;
  end

  assign phase_o = phase_q;
endmodule

// File: rtl/led_select.sv
module led_select
  import keyled_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  op_state_e state,
  input  logic      level_hi,
  input  logic      blink,
  output logic      led_oe_o
);
  logic oe_d, oe_q;

  always_comb begin
    case (state)
      ST_IDLE: oe_d = 1'b0;
      ST_REC:  oe_d = 1'b1;
      ST_PLAY: oe_d = level_hi;
      ST_WIPE: oe_d = blink;
      default: oe_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) oe_q <= 1'b0;
    else        oe_q <= oe_d;
  end

  assign led_oe_o = oe_q;
endmodule

// File: rtl/keyled_ctrl.sv
module keyled_ctrl
  import keyled_pkg::*;
#(
  parameter int TICKS_PER_SEC = 384000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       key_n,
  input  logic       thr_short,
  input  logic [1:0] op_state,
  input  logic       level_hi,
  output logic       sys_rst,
  output logic       play_rst,
  output logic       led_oe,
  output logic       led_lvl
);
  localparam int LONG_TICKS  = 4 * TICKS_PER_SEC;
  localparam int SHORT_TICKS = 2 * TICKS_PER_SEC;
  localparam int FLASH_HALF  = (TICKS_PER_SEC / 4 > 0) ? TICKS_PER_SEC / 4 : 1;

  op_state_e st;
  logic      blink;

  assign st = op_state_e'(op_state);

  press_timer #(
    .LONG_TICKS (LONG_TICKS),
    .SHORT_TICKS(SHORT_TICKS)
  ) u_press (
    .clk       (clk),
    .rst_n     (rst_n),
    .key_n     (key_n),
    .thr_short (thr_short),
    .sys_rst_o (sys_rst),
    .play_rst_o(play_rst)
  );

  blink_gen #(.HALF(FLASH_HALF)) u_blink (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (st == ST_WIPE),
    .phase_o(blink)
  );

  led_select u_led (
    .clk     (clk),
    .rst_n   (rst_n),
    .state   (st),
    .level_hi(level_hi),
    .blink   (blink),
    .led_oe_o(led_oe)
  );

  assign led_lvl = 1'b0;
endmodule

// File: rtl/keyled_chk.sv
module keyled_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       key_n,
  input logic [1:0] op_state,
  input logic       level_hi,
  input logic       sys_rst,
  input logic       play_rst,
  input logic       led_oe
);
  a_r1_sys_while_held: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst |-> $past(key_n) == 1'b0);
  a_r2_play_after_release: assert property (@(posedge clk) disable iff (!rst_n)
    play_rst |-> $past(key_n) == 1'b1);
  a_r5_idle_dark: assert property (@(posedge clk) disable iff (!rst_n)
    (op_state == 2'b00) |=> !led_oe);
  a_r6_rec_lit: assert property (@(posedge clk) disable iff (!rst_n)
    (op_state == 2'b01) |=> led_oe);
  a_r7_play_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (op_state == 2'b10) |=> led_oe == $past(level_hi));
  a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(sys_rst && play_rst));
  a_r10_sys_single: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst |=> !sys_rst);
  a_r10_play_single: assert property (@(posedge clk) disable iff (!rst_n)
    play_rst |=> !play_rst);
endmodule

bind keyled_ctrl keyled_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .key_n   (key_n),
  .op_state(op_state),
  .level_hi(level_hi),
  .sys_rst (sys_rst),
  .play_rst(play_rst),
  .led_oe  (led_oe)
);

// File: tb/tb_keyled_ctrl.sv
module tb_keyled_ctrl;
  localparam int TPS  = 16;
  localparam int HALF = TPS / 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       key_n = 1'b1;
  logic       thr_short = 1'b0;
  logic [1:0] op_state = 2'b00;
  logic       level_hi = 1'b0;
  logic       sys_rst, play_rst, led_oe, led_lvl;
  int         checks = 0;
  int         errors = 0;

  keyled_ctrl #(.TICKS_PER_SEC(TPS)) dut (
    .clk(clk), .rst_n(rst_n), .key_n(key_n), .thr_short(thr_short),
    .op_state(op_state), .level_hi(level_hi), .sys_rst(sys_rst),
    .play_rst(play_rst), .led_oe(led_oe), .led_lvl(led_lvl)
  );

  always #2 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Hold key for len edges, release, observe pulses over the following cycles.
  task automatic press(input int len, input logic sel);
    int thr = sel ? 2 * TPS : 4 * TPS;
    int sys_cnt = 0, play_cnt = 0, sys_at = -1, play_at = -1;
    thr_short = sel;
    key_n = 1'b0;
    for (int i = 1; i <= len + 4; i++) begin
      if (i == len + 1) key_n = 1'b1;
      @(posedge clk); @(negedge clk);
      if (sys_rst)  begin sys_cnt++;  sys_at = i;  end
      if (play_rst) begin play_cnt++; play_at = i; end
      chk("R9 led_lvl", led_lvl, 0);
    end
    if (len >= thr) begin
      chk("R1/R3 sys pulse position", sys_at, thr);
      chk("R4/R10 single sys pulse", sys_cnt, 1);
      chk("R4 no play after long", play_cnt, 0);
    end else begin
      chk("R2/R3 play pulse position", play_at, len + 1);
      chk("R2/R10 single play pulse", play_cnt, 1);
      chk("R2 no sys on short", sys_cnt, 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9 sys_rst reset", sys_rst, 0);
    chk("R9 play_rst reset", play_rst, 0);
    chk("R9 led_oe reset", led_oe, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 R2 R3 R4: sweep press lengths for both thresholds
    for (int s = 0; s < 2; s++) begin
      for (int len = 1; len <= (s ? 2 * TPS : 4 * TPS) + 3; len++) begin
        press(len, s[0]);
      end
    end
    // R3 threshold 4*TPS: a long 2-second-style hold is short at sel 0
    press(2 * TPS + 1, 1'b0);
    // R4 very long hold, single pulse
    press(4 * TPS * 2 + 5, 1'b0);

    // R5 standby ignores level
    op_state = 2'b00;
    for (int i = 0; i < 6; i++) begin
      level_hi = i[0];
      @(posedge clk); @(negedge clk);
      chk("R5 standby led off", led_oe, 0);
    end
    // R6 recording
    op_state = 2'b01;
    for (int i = 0; i < 6; i++) begin
      level_hi = i[1];
      @(posedge clk); @(negedge clk);
      chk("R6 record led on", led_oe, 1);
    end
    // R7 playback follows level
    op_state = 2'b10;
    for (int i = 0; i < 16; i++) begin
      level_hi = (i % 3 == 0);
      @(posedge clk); @(negedge clk);
      chk("R7 play follows level", led_oe, (i % 3 == 0) ? 1 : 0);
    end
    // R8 wiping flash, entered twice
    for (int r = 0; r < 2; r++) begin
      op_state = 2'b11;
      for (int n = 1; n <= 5 * HALF; n++) begin
        @(posedge clk); @(negedge clk);
        chk("R8 wipe flash", led_oe, (((n - 1) / HALF) % 2 == 0) ? 1 : 0);
      end
      op_state = 2'b00;
      @(posedge clk); @(negedge clk);
      chk("R5 standby after wipe", led_oe, 0);
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule